// File: doc/BRIEF.md
# Buck-Boost Burst and Soft-Start Controller

This block is the digital sequencer of a four-switch buck-boost converter. It takes comparator decisions (feedback above an upper hysteresis limit, feedback below a lower limit, inductor current at its peak limit, inductor current at zero, output below a low-voltage threshold) along with fault, enable and mode inputs. From these it drives the four switch enables, a sleep flag and the code for a reference DAC.

In PWM mode the two switch pairs follow phase requests from an external duty generator. In burst mode the block runs a hysteretic loop. It charges the inductor through A and D until the peak-current comparator trips. It then discharges through B and D until the current reaches zero. These bursts repeat until feedback sits above the upper limit. The block then sleeps with every switch off until feedback drops below the lower limit.

A soft-start ramp raises the reference code from zero to full scale in fixed steps. The ramp restarts whenever the converter is enabled or recovers from undervoltage lockout or thermal shutdown. A change of mode never restarts it. Each switch pair gets at least one dead cycle whenever its conducting switch changes.

Top module: `bb_burst_ctrl`

## Requirements
- R1: While the converter is inactive (`en`=0, `uvlo`=1 or `therm_flt`=1), all four switch enables are 0 from the next clock edge on, `sleep` is 0 and `ref_code` is 0.
- R2: While active, `ref_code` rises by exactly one every STEP_CYCLES clock edges, starting from 0. It reaches all-ones and holds there. After N active edges it equals min(N / STEP_CYCLES, 2^DAC_W-1).
- R3: The ramp restarts from 0 after enable or after recovery from `uvlo` or `therm_flt`. Toggling `mode` during the ramp neither resets it nor disturbs it.
- R4: With `mode`=0 (PWM), the A/B pair follows `pwm_ab` (1 = A on, 0 = B on) and the C/D pair follows `pwm_cd` (1 = C on, 0 = D on). The switches lag the request by one clock.
- R5: With `mode`=1 (burst), a burst charges with A and D on until `il_peak`. It then discharges with B and D on until `il_zero`. `il_peak` has no effect during discharge.
- R6: At `il_zero` during discharge, the block enters sleep if `fb_hi`=1, with `sleep`=1 and all switches off. Otherwise it starts a new charge phase.
- R7: Sleep lasts until `fb_lo`=1, which starts a new charge phase. No other comparator ends sleep.
- R8: While `vout_low`=1, burst is disabled, the block follows the PWM behaviour, and switch D is never on.
- R9: A and B are never on together, and C and D are never on together. Any change of the conducting switch within a pair passes through at least one cycle with both switches off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Converter enable |
| mode | input | 1 | 0 = PWM, 1 = burst |
| uvlo | input | 1 | Undervoltage lockout |
| therm_flt | input | 1 | Thermal shutdown |
| vout_low | input | 1 | Output below start-up threshold |
| fb_hi | input | 1 | Feedback above upper hysteresis limit |
| fb_lo | input | 1 | Feedback below lower hysteresis limit |
| il_peak | input | 1 | Inductor current at or above peak limit |
| il_zero | input | 1 | Inductor current at or below zero |
| pwm_ab | input | 1 | PWM request for input pair, 1 = A |
| pwm_cd | input | 1 | PWM request for output pair, 1 = C |
| sw_a | output | 1 | Switch A enable |
| sw_b | output | 1 | Switch B enable |
| sw_c | output | 1 | Switch C enable |
| sw_d | output | 1 | Switch D enable |
| sleep | output | 1 | Burst sleep state |
| ref_code | output | DAC_W | Soft-start reference code |

## Verification
The assertions assume that the comparator and fault inputs are synchronous to `clk` and settle between edges. They rely on the fact that the enable, lockout and thermal inputs are the only inputs that can reset the ramp. The dead-time and pair-exclusion properties make no assumption about the inputs, so any request pattern is legal. The bench changes every input one time unit after a rising edge. It releases `il_peak` and `il_zero` before the next phase needs them, as a real inductor current would, so each comparator event is seen in only one state.

// File: rtl/bb_burst_ctrl.sv
module bb_burst_ctrl #(
  parameter int DAC_W       = 6,
  parameter int STEP_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mode,
  input  logic             uvlo,
  input  logic             therm_flt,
  input  logic             vout_low,
  input  logic             fb_hi,
  input  logic             fb_lo,
  input  logic             il_peak,
  input  logic             il_zero,
  input  logic             pwm_ab,
  input  logic             pwm_cd,
  output logic             sw_a,
  output logic             sw_b,
  output logic             sw_c,
  output logic             sw_d,
  output logic             sleep,
  output logic [DAC_W-1:0] ref_code
);
  localparam int DIV_W = $clog2(STEP_CYCLES + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_CYCLES - 1);
  localparam logic [DAC_W-1:0] REF_MAX = '1;

  typedef enum logic [1:0] {CHG, DIS, SLP} bst_t;

  bst_t st;
  logic [DIV_W-1:0] div_q;
  logic [1:0] ab_q, cd_q, ab_w, cd_w;

  wire active   = en && !uvlo && !therm_flt;
  wire burst_on = active && mode && !vout_low;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_code <= '0;
      div_q    <= '0;
    end else if (!active) begin
      ref_code <= '0;
      div_q    <= '0;
    end else if (ref_code != REF_MAX) begin
      if (div_q == DIV_LAST) begin
        div_q    <= '0;
        ref_code <= ref_code + 1'b1;
      end else
        div_q <= div_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      st <= CHG;
    else if (!burst_on)
      st <= CHG;
    else
      case (st)
        CHG:     if (il_peak) st <= DIS;
        DIS:     if (il_zero) st <= fb_hi ? SLP : CHG;
        SLP:     if (fb_lo)   st <= CHG;
        default: st <= CHG;
      endcase

  always_comb begin
    ab_w = 2'b00;
    cd_w = 2'b00;
    if (burst_on) begin
      case (st)
        CHG:     begin ab_w = 2'b10; cd_w = 2'b01; end
        DIS:     begin ab_w = 2'b01; cd_w = 2'b01; end
        default: begin ab_w = 2'b00; cd_w = 2'b00; end
      endcase
    end else if (active) begin
      ab_w = pwm_ab ? 2'b10 : 2'b01;
      cd_w = pwm_cd ? 2'b10 : 2'b01;
    end
    if (vout_low) cd_w[0] = 1'b0;
  end

  function automatic logic [1:0] step_pair(input logic [1:0] cur, input logic [1:0] want);
    return (cur != 2'b00 && cur != want) ? 2'b00 : want;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ab_q <= 2'b00;
      cd_q <= 2'b00;
    end else begin
      ab_q <= step_pair(ab_q, ab_w);
      cd_q <= step_pair(cd_q, cd_w);
    end

  assign sw_a  = ab_q[1];
  assign sw_b  = ab_q[0];
  assign sw_c  = cd_q[1];
  assign sw_d  = cd_q[0];
  assign sleep = (st == SLP);
endmodule

module bb_burst_ctrl_chk #(
  parameter int DAC_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             uvlo,
  input logic             therm_flt,
  input logic             vout_low,
  input logic             sw_a,
  input logic             sw_b,
  input logic             sw_c,
  input logic             sw_d,
  input logic             sleep,
  input logic [DAC_W-1:0] ref_code
);
  wire act = en && !uvlo && !therm_flt;

  assert_pair_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_a && sw_b) && !(sw_c && sw_d));
  assert_dead_ab_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_a |=> !sw_b) and (sw_b |=> !sw_a));
  assert_dead_cd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_c |=> !sw_d) and (sw_d |=> !sw_c));
  assert_off_inactive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> (!sw_a && !sw_b && !sw_c && !sw_d && !sleep && ref_code == '0));
  assert_ramp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> (ref_code == $past(ref_code) || ref_code == $past(ref_code) + 1'b1));
  assert_d_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vout_low |=> !sw_d);
  assert_sleep_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && $past(sleep)) |-> (!sw_a && !sw_b && !sw_c && !sw_d));
endmodule

bind bb_burst_ctrl bb_burst_ctrl_chk #(.DAC_W(DAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .uvlo(uvlo), .therm_flt(therm_flt),
  .vout_low(vout_low), .sw_a(sw_a), .sw_b(sw_b), .sw_c(sw_c), .sw_d(sw_d),
  .sleep(sleep), .ref_code(ref_code));

// File: tb/bb_burst_ctrl_bench.sv
module bb_burst_ctrl_bench;
  localparam int DAC_W = 6;
  localparam int STEP  = 4;

  logic clk = 0, rst_n = 0;
  logic en = 0, mode = 0, uvlo = 0, therm_flt = 0, vout_low = 0;
  logic fb_hi = 0, fb_lo = 0, il_peak = 0, il_zero = 0, pwm_ab = 0, pwm_cd = 0;
  logic sw_a, sw_b, sw_c, sw_d, sleep;
  logic [DAC_W-1:0] ref_code;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bb_burst_ctrl #(.DAC_W(DAC_W), .STEP_CYCLES(STEP)) u_bb_burst_ctrl (.*);

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sw4();
    return {sw_a, sw_b, sw_c, sw_d};
  endfunction

  task automatic t_reset();
    chk("R1 reset switches", sw4(), 0);
    chk("R1 reset sleep", sleep, 0);
    chk("R1 reset ref", ref_code, 0);
  endtask

  task automatic t_ramp();
    en = 1;
    tick(10);
    chk("R2 ramp after 10", ref_code, 10 / STEP);
    tick(30);
    chk("R2 ramp after 40", ref_code, 40 / STEP);
    tick(300);
    chk("R2 ramp full scale", ref_code, 63);
    tick(20);
    chk("R2 ramp holds", ref_code, 63);
  endtask

  task automatic t_pwm();
    mode = 0; pwm_ab = 1; pwm_cd = 0;
    tick(3);
    chk("R4 pwm A,D", sw4(), 4'b1001);
    pwm_ab = 0;
    tick(1);
    chk("R9 dead cycle ab", {sw_a, sw_b}, 0);
    tick(1);
    chk("R4 pwm B", sw4(), 4'b0101);
    pwm_cd = 1;
    tick(1);
    chk("R9 dead cycle cd", {sw_c, sw_d}, 0);
    tick(1);
    chk("R4 pwm C", sw4(), 4'b0110);
    pwm_cd = 0;
    tick(3);
  endtask

  task automatic t_burst();
    mode = 1; fb_hi = 0; fb_lo = 0;
    tick(3);
    chk("R5 charge A,D", sw4(), 4'b1001);
    il_peak = 1;
    tick(1);
    chk("R5 still charging one edge", sw4(), 4'b1001);
    tick(1);
    chk("R9 burst dead cycle", sw4(), 4'b0001);
    tick(1);
    chk("R5 discharge B,D", sw4(), 4'b0101);
    tick(2);
    chk("R5 il_peak ignored in discharge", sw4(), 4'b0101);
    il_peak = 0; il_zero = 1;
    tick(1);
    il_zero = 0;
    tick(2);
    chk("R6 recharge when fb not high", sw4(), 4'b1001);
    chk("R6 no sleep", sleep, 0);
    il_peak = 1; tick(1); il_peak = 0;
    tick(3);
    chk("R5 second discharge", sw4(), 4'b0101);
    fb_hi = 1; il_zero = 1;
    tick(1);
    il_zero = 0;
    chk("R6 sleep entered", sleep, 1);
    tick(1);
    chk("R6 sleep switches off", sw4(), 0);
    fb_hi = 0; il_peak = 1; il_zero = 1;
    tick(3);
    chk("R7 only fb_lo ends sleep", sleep, 1);
    il_peak = 0; il_zero = 0; fb_lo = 1;
    tick(1);
    fb_lo = 0;
    chk("R7 sleep left", sleep, 0);
    tick(1);
    chk("R7 charge after wake", sw4(), 4'b1001);
  endtask

  task automatic t_lowvout();
    vout_low = 1; pwm_ab = 1; pwm_cd = 0;
    tick(3);
    chk("R8 burst disabled, A on, D off", sw4(), 4'b1000);
    il_peak = 1; tick(2); il_peak = 0;
    chk("R8 no burst phase change", sw4(), 4'b1000);
    chk("R8 no sleep", sleep, 0);
    vout_low = 0;
    tick(3);
    chk("R8 burst resumes A,D", sw4(), 4'b1001);
  endtask

  task automatic t_fault(input bit use_uvlo);
    if (use_uvlo) uvlo = 1; else therm_flt = 1;
    tick(1);
    chk("R1 fault switches off", sw4(), 0);
    chk("R1 fault ref zero", ref_code, 0);
    tick(3);
    chk("R1 fault held", ref_code, 0);
    uvlo = 0; therm_flt = 0;
    tick(9);
    chk("R3 ramp restarts after fault", ref_code, 9 / STEP);
  endtask

  task automatic t_mode_change();
    en = 0; tick(2);
    en = 1; tick(8);
    mode = ~mode;
    tick(4);
    chk("R3 mode change keeps ramp", ref_code, 12 / STEP);
    mode = ~mode;
    tick(4);
    chk("R3 second mode change keeps ramp", ref_code, 16 / STEP);
  endtask

  initial begin
    #1;
    t_reset();
    tick(2);
    rst_n = 1;
    tick(1);
    t_reset();
    t_ramp();
    t_pwm();
    t_burst();
    t_lowvout();
    t_fault(1);
    t_fault(0);
    t_mode_change();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule